// File: doc/BRIEF.md
# Error-Driven Timing Delay Adjuster

This block sits beside a card host controller's timing configuration. When a card transaction finishes, the controller offers one completion event carrying the error flags, the 3-bit CRC token result, the tuning-enable and error-state bits, and a snapshot of the five 3-bit timing delay fields. The block works out which error was most significant, names its class (timeout or CRC sequence error) and picks at most one delay field to step forward by one.

The adjusted set of fields is held back until the controller reports that its soft reset has completed. In the cycle after that report the block drives the new fields and the class on its outputs and pulses a one-cycle update strobe, so that the timing configuration can be reloaded after the reset has cleared it. The outputs then hold their values until the next update.

Events enter over a valid/ready handshake. Ready is high only when no event is pending; an event is taken on a clock edge where both are high. While an event waits for the soft-reset report, ready stays low and the producer must hold its event, which is neither taken nor allowed to disturb the pending result. The soft-reset report, the strobe and the class are plain control and status pins.

Top module: `dly_tune_adjuster`

## Requirements
- R1: With the error-state bit set, a response timeout wins over every other flag: the class is timeout (code 1) and the write-command field (index 0) is incremented.
- R2: A response CRC7 error with no response timeout gives class CRC (code 2) and increments the read-response field (index 2).
- R3: The four data-phase flags are considered only when the has-data bit is set; without it and without a response flag the class is none (code 0) and every field is returned unchanged.
- R4: Among data-phase flags, a start-bit timeout comes first (class timeout, read-data field index 3), then a read-data CRC16 error (class CRC, read-data field index 3).
- R5: After those, a card CRC status timeout gives class timeout and increments the read-CRC field (index 4).
- R6: Last, a CRC token error gives class CRC; it increments the write-data field (index 1) when the token result equals 5 and the read-CRC field (index 4) for any other token value.
- R7: Fields change only when both tuning-enable and the error-state bit are set; with tuning disabled the class is still reported, and with the error-state bit clear the class is none.
- R8: An incremented field wraps from 7 to 0.
- R9: At most one field differs between the applied set and the snapshot taken with the event.
- R10: The result is applied, with a one-cycle strobe, in the cycle after the soft-reset-done input is seen high while an event is pending; soft-reset-done with no event pending has no effect, and outputs hold between strobes.
- R11: Ready falls after an event is taken and rises again only with the strobe; an event offered while not ready is not taken and does not alter the pending result.
- R12: After reset, the delay outputs are all zero, the class is none, the strobe is low and ready is high.

Field i of a delay vector occupies bits [3i+2:3i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Completion event offered |
| evt_ready | output | 1 | Block can take an event |
| tune_en | input | 1 | Delay adjustment allowed |
| state_err | input | 1 | Transaction ended in error |
| has_data | input | 1 | Transaction had a data phase |
| rsp_timeout | input | 1 | No response received |
| rsp_crc_err | input | 1 | Response CRC7 mismatch |
| start_timeout | input | 1 | Data start bit not seen |
| rdat_crc_err | input | 1 | Read data CRC16 mismatch |
| crc_stat_timeout | input | 1 | Card CRC status not returned |
| token_err | input | 1 | CRC token check failed |
| token_result | input | 3 | CRC token value returned by the card |
| cur_dly | input | 15 | Current delay fields |
| srst_done | input | 1 | Controller soft reset has completed |
| upd_strobe | output | 1 | One-cycle pulse: new fields valid |
| new_dly | output | 15 | Updated delay fields, held between strobes |
| err_class | output | 2 | 0 none, 1 timeout, 2 CRC error |

## Verification
A wrong priority decode shows as the wrong field stepping or the wrong class code on the very strobe that follows the soft-reset report, so every event exposes it within a few cycles of its acceptance. A sequencer stuck in the pending state shows as ready staying low and no strobe after soft-reset-done; one that leaves it early shows as a strobe without a prior soft-reset report, or as a later event overwriting the pending result. A lost hold shows as the delay outputs moving while the strobe is low.

// File: rtl/dly_adj_pkg.sv
package dly_adj_pkg;

  localparam int NUM_FIELDS = 5;

  // field indices inside a packed delay vector
  localparam int F_WR_CMD = 0;
  localparam int F_WR_DAT = 1;
  localparam int F_RD_RSP = 2;
  localparam int F_RD_DAT = 3;
  localparam int F_RD_CRC = 4;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_TIMEOUT = 2'd1,
    CLS_CRC     = 2'd2
  } err_class_e;

  typedef struct packed {
    logic tune_en;
    logic state_err;
    logic has_data;
    logic rsp_timeout;
    logic rsp_crc_err;
    logic start_timeout;
    logic rdat_crc_err;
    logic crc_stat_timeout;
    logic token_err;
  } fault_flags_t;

endpackage

// File: rtl/dly_fault_classifier.sv
module dly_fault_classifier
  import dly_adj_pkg::*;
#(
  parameter int TOKEN_W    = 3,
  parameter int TOKEN_WBAD = 5
) (
  input  fault_flags_t           flags,
  input  logic [TOKEN_W-1:0]     token,
  output logic [NUM_FIELDS-1:0]  sel,
  output err_class_e             cls
);

  localparam logic [TOKEN_W-1:0] TOK_BAD = TOKEN_W'(TOKEN_WBAD);

  logic [NUM_FIELDS-1:0] raw_sel;
  err_class_e            raw_cls;

  // fixed priority: response phase first, then data phase in order
  always_comb begin
    raw_sel = '0;
    raw_cls = CLS_NONE;
    if (flags.rsp_timeout) begin
      raw_cls = CLS_TIMEOUT;
      raw_sel[F_WR_CMD] = 1'b1;
    end else if (flags.rsp_crc_err) begin
      raw_cls = CLS_CRC;
      raw_sel[F_RD_RSP] = 1'b1;
    end else if (flags.has_data) begin
      if (flags.start_timeout) begin
        raw_cls = CLS_TIMEOUT;
        raw_sel[F_RD_DAT] = 1'b1;
      end else if (flags.rdat_crc_err) begin
        raw_cls = CLS_CRC;
        raw_sel[F_RD_DAT] = 1'b1;
      end else if (flags.crc_stat_timeout) begin
        raw_cls = CLS_TIMEOUT;
        raw_sel[F_RD_CRC] = 1'b1;
      end else if (flags.token_err) begin
        raw_cls = CLS_CRC;
        if (token == TOK_BAD) raw_sel[F_WR_DAT] = 1'b1;
        else                  raw_sel[F_RD_CRC] = 1'b1;
      end
    end
  end

  // class needs an error state; a field step also needs tuning
  always_comb begin
    cls = flags.state_err ? raw_cls : CLS_NONE;
    sel = (flags.state_err && flags.tune_en) ? raw_sel : '0;
  end

endmodule

// File: rtl/dly_field_bumper.sv
module dly_field_bumper
  import dly_adj_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic [NUM_FIELDS*DLY_W-1:0] cur,
  input  logic [NUM_FIELDS-1:0]       sel,
  output logic [NUM_FIELDS*DLY_W-1:0] nxt
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [DLY_W-1:0] fld;
    assign fld = cur[i*DLY_W +: DLY_W];
    // modular add: the top value rolls back to zero
    assign nxt[i*DLY_W +: DLY_W] = sel[i] ? fld + ONE : fld;
  end

endmodule

// File: rtl/dly_apply_seq.sv
module dly_apply_seq
  import dly_adj_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        evt_valid,
  output logic                        evt_ready,
  input  logic [NUM_FIELDS*DLY_W-1:0] base_in,
  input  logic [NUM_FIELDS*DLY_W-1:0] nxt_in,
  input  err_class_e                  cls_in,
  input  logic                        srst_done,
  output logic                        upd_strobe,
  output logic [NUM_FIELDS*DLY_W-1:0] dly_out,
  output err_class_e                  cls_out
);

  localparam int VW = NUM_FIELDS * DLY_W;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_st_e;

  seq_st_e        st;
  logic [VW-1:0]  pend_q;
  logic [VW-1:0]  base_q;
  err_class_e     pcls_q;

  assign evt_ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pend_q     <= '0;
      base_q     <= '0;
      pcls_q     <= CLS_NONE;
      dly_out    <= '0;
      cls_out    <= CLS_NONE;
      upd_strobe <= 1'b0;
    end else begin
      upd_strobe <= 1'b0;
      case (st)
        ST_IDLE: if (evt_valid) begin
          pend_q <= nxt_in;
          base_q <= base_in;
          pcls_q <= cls_in;
          st     <= ST_WAIT;
        end
        ST_WAIT: if (srst_done) begin
          dly_out    <= pend_q;
          cls_out    <= pcls_q;
          upd_strobe <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // per-field difference between applied set and its snapshot
  logic [NUM_FIELDS-1:0] diff;
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_diff
    assign diff[i] = dly_out[i*DLY_W +: DLY_W] != base_q[i*DLY_W +: DLY_W];
  end

  a_r9_single_field: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> $countones(diff) <= 1);

  a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  a_r10_after_reset_done: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> $past(srst_done));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |-> $stable(dly_out) && $stable(cls_out));

  a_r11_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> !evt_ready);

  a_r11_ready_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(evt_ready)) |-> upd_strobe);

endmodule

// File: rtl/dly_tune_adjuster.sv
module dly_tune_adjuster
  import dly_adj_pkg::*;
#(
  parameter int DLY_W      = 3,
  parameter int TOKEN_W    = 3,
  parameter int TOKEN_WBAD = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              evt_valid,
  output logic                              evt_ready,
  input  logic                              tune_en,
  input  logic                              state_err,
  input  logic                              has_data,
  input  logic                              rsp_timeout,
  input  logic                              rsp_crc_err,
  input  logic                              start_timeout,
  input  logic                              rdat_crc_err,
  input  logic                              crc_stat_timeout,
  input  logic                              token_err,
  input  logic [TOKEN_W-1:0]                token_result,
  input  logic [NUM_FIELDS*DLY_W-1:0]       cur_dly,
  input  logic                              srst_done,
  output logic                              upd_strobe,
  output logic [NUM_FIELDS*DLY_W-1:0]       new_dly,
  output logic [1:0]                        err_class
);

  localparam int VW = NUM_FIELDS * DLY_W;

  fault_flags_t          flags;
  logic [NUM_FIELDS-1:0] sel;
  err_class_e            cls;
  err_class_e            cls_q;
  logic [VW-1:0]         nxt;

  assign flags = '{tune_en: tune_en, state_err: state_err, has_data: has_data,
                   rsp_timeout: rsp_timeout, rsp_crc_err: rsp_crc_err,
                   start_timeout: start_timeout, rdat_crc_err: rdat_crc_err,
                   crc_stat_timeout: crc_stat_timeout, token_err: token_err};

  dly_fault_classifier #(.TOKEN_W(TOKEN_W), .TOKEN_WBAD(TOKEN_WBAD)) u_cls (
    .flags (flags),
    .token (token_result),
    .sel   (sel),
    .cls   (cls)
  );

  dly_field_bumper #(.DLY_W(DLY_W)) u_bump (
    .cur (cur_dly),
    .sel (sel),
    .nxt (nxt)
  );

  dly_apply_seq #(.DLY_W(DLY_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_ready  (evt_ready),
    .base_in    (cur_dly),
    .nxt_in     (nxt),
    .cls_in     (cls),
    .srst_done  (srst_done),
    .upd_strobe (upd_strobe),
    .dly_out    (new_dly),
    .cls_out    (cls_q)
  );

  assign err_class = cls_q;

  a_r1_rsp_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (state_err && rsp_timeout) |-> cls == CLS_TIMEOUT &&
      (sel == '0 || sel[F_WR_CMD]));

  a_r2_rsp_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (state_err && !rsp_timeout && rsp_crc_err) |-> cls == CLS_CRC &&
      (sel == '0 || sel[F_RD_RSP]));

  a_r3_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_data && !rsp_timeout && !rsp_crc_err) |-> cls == CLS_NONE && sel == '0);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!tune_en || !state_err) |-> sel == '0);

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

endmodule

// File: tb/tb_dly_tune_adjuster.sv
module tb_dly_tune_adjuster;

  localparam int NF = 5;
  localparam int DW = 3;
  localparam int VW = NF * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic evt_ready;
  logic tune_en = 1'b0, state_err = 1'b0, has_data = 1'b0;
  logic rsp_timeout = 1'b0, rsp_crc_err = 1'b0, start_timeout = 1'b0;
  logic rdat_crc_err = 1'b0, crc_stat_timeout = 1'b0, token_err = 1'b0;
  logic [2:0] token_result = '0;
  logic [VW-1:0] cur_dly = '0;
  logic srst_done = 1'b0;
  logic upd_strobe;
  logic [VW-1:0] new_dly;
  logic [1:0] err_class;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dly_tune_adjuster dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .tune_en(tune_en), .state_err(state_err), .has_data(has_data),
    .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err),
    .start_timeout(start_timeout), .rdat_crc_err(rdat_crc_err),
    .crc_stat_timeout(crc_stat_timeout), .token_err(token_err),
    .token_result(token_result), .cur_dly(cur_dly), .srst_done(srst_done),
    .upd_strobe(upd_strobe), .new_dly(new_dly), .err_class(err_class)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference priority model from the requirements
  task automatic ref_model(input logic [11:0] v, output int fld, output int cls,
                           output string tag);
    logic rto, c7, hd, stb, c16, cst, tok, te, se;
    logic [2:0] tk;
    {se, te, tk, tok, cst, c16, stb, hd, c7, rto} = v;
    fld = -1; cls = 0; tag = "R3";
    if (rto)      begin cls = 1; fld = 0; tag = "R1"; end
    else if (c7)  begin cls = 2; fld = 2; tag = "R2"; end
    else if (hd) begin
      if (stb)       begin cls = 1; fld = 3; tag = "R4"; end
      else if (c16)  begin cls = 2; fld = 3; tag = "R4"; end
      else if (cst)  begin cls = 1; fld = 4; tag = "R5"; end
      else if (tok)  begin cls = 2; fld = (tk == 3'd5) ? 1 : 4; tag = "R6"; end
    end
    if (!se) begin cls = 0; fld = -1; tag = "R7"; end
    else if (!te) begin fld = -1; tag = "R7"; end
  endtask

  task automatic drive_flags(input logic [11:0] v, input logic [VW-1:0] cur);
    {state_err, tune_en, token_result, token_err, crc_stat_timeout, rdat_crc_err,
     start_timeout, has_data, rsp_crc_err, rsp_timeout} = v;
    cur_dly = cur;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [VW-1:0] prev_dly;
    logic [1:0]    prev_cls;
    prev_dly = '0;
    prev_cls = 2'd0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 dly", 32'(new_dly), 32'd0);
    chk("R12 cls", 32'(err_class), 32'd0);
    chk("R12 strobe", 32'(upd_strobe), 32'd0);
    chk("R12 ready", 32'(evt_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 4096; v++) begin
      logic [VW-1:0] cur, exp_dly;
      int fld, cls, nchg;
      string tag;
      for (int i = 0; i < NF; i++) cur[i*DW +: DW] = 3'((v * 5 + i * 3) % 8);
      ref_model(12'(v), fld, cls, tag);
      exp_dly = cur;
      if (fld >= 0) begin
        exp_dly[fld*DW +: DW] = 3'((int'(cur[fld*DW +: DW]) + 1) % 8);
        if (cur[fld*DW +: DW] == 3'd7) tag = {tag, "/R8"};
      end

      // idle soft-reset report must do nothing
      if (v % 64 == 0) begin
        srst_done = 1'b1;
        @(negedge clk);
        srst_done = 1'b0;
        chk("R10 idle srst strobe", 32'(upd_strobe), 32'd0);
        chk("R10 idle srst hold", 32'(new_dly), 32'(prev_dly));
      end

      drive_flags(12'(v), cur);
      evt_valid = 1'b1;
      @(negedge clk);
      chk("R11 ready low", 32'(evt_ready), 32'd0);
      // offer a different event while busy: must be ignored
      drive_flags(~12'(v), ~cur);
      for (int w = 0; w < v % 3; w++) begin
        @(negedge clk);
        chk("R10 no early strobe", 32'(upd_strobe), 32'd0);
        chk("R10 hold", 32'(new_dly), 32'(prev_dly));
      end
      srst_done = 1'b1;
      @(negedge clk);
      srst_done = 1'b0;
      evt_valid = 1'b0;
      chk("R10 strobe", 32'(upd_strobe), 32'd1);
      chk({tag, " dly"}, 32'(new_dly), 32'(exp_dly));
      chk({tag, " cls"}, 32'(err_class), 32'(cls));
      nchg = 0;
      for (int i = 0; i < NF; i++)
        if (new_dly[i*DW +: DW] != cur[i*DW +: DW]) nchg++;
      chk("R9 fields changed", 32'(nchg <= 1), 32'd1);
      prev_dly = exp_dly;
      prev_cls = 2'(cls);
      @(negedge clk);
      chk("R10 strobe one cycle", 32'(upd_strobe), 32'd0);
      chk("R11 ready back", 32'(evt_ready), 32'd1);
      chk("R10 cls hold", 32'(err_class), 32'(prev_cls));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule